// File: doc/BRIEF.md
# Apparent Energy Integrator with Programmable Divider

This block turns a stream of signed per-phase apparent-power words into an energy reading. On a fixed cadence of one sample per twelve clocks it adds the three phase words together and folds the total into a wide two's-complement accumulator. The accumulator itself is not visible. What is visible is its value divided by an 8-bit software divisor, with only the top 24 bits of the quotient shown.

A second accumulator runs alongside the first and takes the same samples. A read strobe clears it, so software can read energy per interval without losing any sample. A sticky interrupt flag marks the moment the visible energy first reaches half of full scale, in either sign.

Top module: `vaen_accum`

## Requirements
- R1: While reset is high and on the first cycle after it, `energy`, `energy_rc` and `irq_flag` are all zero.
- R2: An accumulation happens once every `TICK_CYCLES` (12) clocks. The first one takes place on the 12th rising edge after reset is released, using the power inputs present at that edge. No accumulator changes between accumulations.
- R3: The sample added is the sum of the three phase words. Each word is a 24-bit two's-complement value, and phase i sits in `pwr_bus[24*i +: 24]`. The sum is sign-extended and added with signed arithmetic, so a negative total lowers the energy.
- R4: `energy` is bits [ACC_W-1:ACC_W-24] of the accumulator divided by `div_sel`, where the quotient truncates toward zero. A `div_sel` of 0 behaves as 1.
- R5: The accumulator wraps modulo 2^ACC_W. With positive power, `energy` goes from 0x7FFFFF to 0x800000 and keeps increasing from there.
- R6: `energy_rc` applies the R4 scaling to a shadow accumulator that takes the same samples. While `rd_strobe` is high, `energy_rc` shows the value before the clear. When there is no accumulation on that edge, the shadow reads zero after the edge.
- R7: When `rd_strobe` falls on an accumulation edge, the shadow is loaded with that edge's sample instead of zero, so the sample is not lost.
- R8: The half-full zone is `energy[23:22]` equal to 01 or 10. When `irq_en` is high, `irq_flag` sets on the clock edge after `energy` moves into the zone from outside it. When `irq_en` is low, entering the zone does not set the flag.
- R9: `irq_flag` stays set until an edge where `irq_ack` is high. A new set on that same edge takes priority over the ack.
- R10: The wrap from 0x7FFFFF to 0x800000 stays inside the zone, so it does not set `irq_flag` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_bus | input | NPH*PWR_W | Packed signed per-phase apparent-power words |
| div_sel | input | 8 | Unsigned energy divisor, 0 treated as 1 |
| rd_strobe | input | 1 | Read of the clear-on-read register |
| irq_en | input | 1 | Enables setting of the half-full flag |
| irq_ack | input | 1 | Clears the half-full flag |
| energy | output | 24 | Scaled energy register |
| energy_rc | output | 24 | Scaled clear-on-read energy register |
| irq_flag | output | 1 | Sticky half-full interrupt flag |

## Verification
The hardest states to reach from the ports are the half-full crossing and the wrap to full-scale negative. Each one needs a very large number of accumulated samples. The bench therefore builds the block with a narrower accumulator and holds all three phases at near full-scale power. It then waits on its own model until the predicted energy crosses each threshold. Hitting a read on the exact accumulation edge is a second hard case. The bench solves it by tracking the sampling cadence in its model and raising the strobe on the predicted tick cycle.

// File: rtl/vaen_pkg.sv
package vaen_pkg;
    localparam int DIV_W = 8;
    localparam int OUT_W = 24;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [OUT_W-1:0] energy_t;

    typedef enum logic [0:0] {
        ZONE_LOW  = 1'b0,
        ZONE_HALF = 1'b1
    } zone_e;

    // A divisor of zero is served as one
    function automatic div_t div_eff(input div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    // Magnitude at or above half scale when the two top bits differ
    function automatic zone_e zone_of(input energy_t e);
        return (e[OUT_W-1] ^ e[OUT_W-2]) ? ZONE_HALF : ZONE_LOW;
    endfunction
endpackage

// File: rtl/vaen_tick.sv
module vaen_tick #(
    parameter int TICK_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/vaen_integ.sv
module vaen_integ #(
    parameter int W = 49
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                clr,
    input  logic signed [W-1:0] add,
    output logic signed [W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)        acc <= '0;
        else if (clr)   acc <= tick ? add : '0;
        else if (tick)  acc <= acc + add;
    end
endmodule

// File: rtl/vaen_scale.sv
module vaen_scale
    import vaen_pkg::*;
#(
    parameter int W = 49
) (
    input  logic signed [W-1:0] acc,
    input  div_t                div_sel,
    output energy_t             energy
);
    logic signed [W-1:0] den;
    logic signed [W-1:0] quo;

    always_comb begin
        den = {{(W-DIV_W){1'b0}}, div_eff(div_sel)};
        quo = acc / den;
    end

    assign energy = quo[W-1 -: OUT_W];
endmodule

// File: rtl/vaen_halfirq.sv
module vaen_halfirq
    import vaen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  energy_t energy,
    input  logic    irq_en,
    input  logic    irq_ack,
    output logic    irq_flag
);
    zone_e zone_now, zone_q;
    logic  enter;

    assign zone_now = zone_of(energy);
    assign enter    = (zone_now == ZONE_HALF) && (zone_q == ZONE_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            zone_q   <= ZONE_LOW;
            irq_flag <= 1'b0;
        end else begin
            zone_q <= zone_now;
            if (irq_en && enter) irq_flag <= 1'b1;
            else if (irq_ack)    irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/vaen_accum.sv
module vaen_accum
    import vaen_pkg::*;
#(
    parameter int ACC_W       = 49,
    parameter int PWR_W       = 24,
    parameter int NPH         = 3,
    parameter int TICK_CYCLES = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPH*PWR_W-1:0] pwr_bus,
    input  logic [DIV_W-1:0]     div_sel,
    input  logic                 rd_strobe,
    input  logic                 irq_en,
    input  logic                 irq_ack,
    output logic [OUT_W-1:0]     energy,
    output logic [OUT_W-1:0]     energy_rc,
    output logic                 irq_flag
);
    localparam int NACC = 2;   // 0: running, 1: clear-on-read shadow

    logic                    tick;
    logic signed [ACC_W-1:0] sum_ext;
    logic signed [ACC_W-1:0] acc_v [NACC];
    energy_t                 en_v  [NACC];

    vaen_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    always_comb begin
        sum_ext = '0;
        for (int i = 0; i < NPH; i++) begin
            logic signed [PWR_W-1:0] w;
            w       = pwr_bus[i*PWR_W +: PWR_W];
            sum_ext = sum_ext + ACC_W'(w);
        end
    end

    for (genvar g = 0; g < NACC; g++) begin : g_path
        vaen_integ #(.W(ACC_W)) u_integ (
            .clk (clk),
            .rst (rst),
            .tick(tick),
            .clr ((g == 1) ? rd_strobe : 1'b0),
            .add (sum_ext),
            .acc (acc_v[g])
        );
        vaen_scale #(.W(ACC_W)) u_scale (
            .acc    (acc_v[g]),
            .div_sel(div_sel),
            .energy (en_v[g])
        );
    end

    assign energy    = en_v[0];
    assign energy_rc = en_v[1];

    vaen_halfirq u_irq (
        .clk     (clk),
        .rst     (rst),
        .energy  (en_v[0]),
        .irq_en  (irq_en),
        .irq_ack (irq_ack),
        .irq_flag(irq_flag)
    );
endmodule

// File: rtl/vaen_chk.sv
module vaen_chk #(
    parameter int ACC_W = 49
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic                    rd_strobe,
    input logic                    irq_en,
    input logic                    irq_ack,
    input logic                    irq_flag,
    input logic signed [ACC_W-1:0] acc_main,
    input logic signed [ACC_W-1:0] acc_rc,
    input logic signed [ACC_W-1:0] sum_ext
);
    // R2: no change in the running accumulator off the sampling edge
    a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(acc_main));

    // R2: two accumulations never fall on adjacent edges
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R6: a read without a sample leaves the shadow at zero
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !tick) |=> (acc_rc == '0));

    // R7: a read on a sampling edge keeps that edge's sample
    a_r7_read_keeps_sample: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && tick) |=> (acc_rc == $past(sum_ext)));

    // R8: the flag only rises while enabled
    a_r8_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(irq_en));

    // R9: the flag is sticky until acknowledged
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_ack) |=> irq_flag);
endmodule

bind vaen_accum vaen_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rd_strobe(rd_strobe),
    .irq_en   (irq_en),
    .irq_ack  (irq_ack),
    .irq_flag (irq_flag),
    .acc_main (acc_v[0]),
    .acc_rc   (acc_v[1]),
    .sum_ext  (sum_ext)
);

// File: tb/test_vaen_accum.sv
module test_vaen_accum;
    localparam int AW = 36;   // narrowed accumulator to reach the wrap quickly
    localparam int PW = 24;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pa = '0, pb = '0, pc = '0;
    logic [7:0]  dsel = '0;
    logic        rd = 1'b0, ien = 1'b0, iack = 1'b0;
    logic [23:0] energy, energy_rc;
    logic        irq_flag;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vaen_accum #(.ACC_W(AW)) i_vaen_accum (
        .clk(clk), .rst(rst), .pwr_bus({pc, pb, pa}), .div_sel(dsel),
        .rd_strobe(rd), .irq_en(ien), .irq_ack(iack),
        .energy(energy), .energy_rc(energy_rc), .irq_flag(irq_flag)
    );

    // ---------------- reference model built from the requirements ----------
    logic signed [AW-1:0] macc, mrc;
    int  mcnt;
    logic mzq, mirq;

    function automatic logic signed [AW-1:0] msum();
        return AW'($signed(pa)) + AW'($signed(pb)) + AW'($signed(pc));
    endfunction

    function automatic logic [23:0] mscale(input logic signed [AW-1:0] a,
                                           input logic [7:0] d);
        longint aa = longint'(a);
        longint dd = (d == 0) ? 64'sd1 : longint'({56'd0, d});
        longint q  = aa / dd;
        return 24'((q >>> (AW - 24)) & 64'hFF_FFFF);
    endfunction

    function automatic logic mzone(input logic [23:0] e);
        return e[23] ^ e[22];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mcnt <= 0; macc <= '0; mrc <= '0; mzq <= 1'b0; mirq <= 1'b0;
        end else begin
            logic t;
            logic z;
            t = (mcnt == 11);
            z = mzone(mscale(macc, dsel));
            mcnt <= t ? 0 : mcnt + 1;
            if (t) macc <= macc + msum();
            if (rd)     mrc <= t ? msum() : '0;
            else if (t) mrc <= mrc + msum();
            mzq <= z;
            if (ien && z && !mzq) mirq <= 1'b1;
            else if (iack)        mirq <= 1'b0;
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, energy, mscale(macc, dsel));
        chk(req, energy_rc, mscale(mrc, dsel));
        chk(req, {23'd0, irq_flag}, {23'd0, mirq});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // {pa, pb, pc, div, cycles}
    localparam logic [95:0] VEC [NV] = '{
        {24'h100000, 24'h100000, 24'h100000, 8'd1,   16'd60},   // R3 positive
        {24'h200000, 24'hF00000, 24'h000000, 8'd0,   16'd36},   // R3 mixed, R4 div 0
        {24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 8'd3,   16'd120},  // R4 div 3
        {24'h800000, 24'h800000, 24'h800000, 8'd1,   16'd240},  // R3 negative total
        {24'h400000, 24'h000000, 24'hC00000, 8'd2,   16'd48},   // R3 cancelling phases
        {24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 8'd255, 16'd96},   // R4 divisor 255
        {24'h000123, 24'h000456, 24'h000789, 8'd1,   16'd24},   // R3 small words
        {24'h300000, 24'h300000, 24'h300000, 8'd7,   16'd84}    // R4 div 7
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [23:0] e1, e2;
        // R1: reset state, during reset and on the first cycle after it
        repeat (3) @(negedge clk);
        chk("R1", energy, 24'd0); chk("R1", energy_rc, 24'd0); chk("R1", {23'd0, irq_flag}, 24'd0);
        pa = 24'h100000; pb = 24'h100000; pc = 24'h100000; dsel = 8'd1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", energy, 24'd0); chk("R1", energy_rc, 24'd0);

        // R2: nothing after 11 edges, first sample at the 12th
        repeat (10) @(negedge clk);
        chk("R2 before first sample", energy, 24'd0);
        @(negedge clk);
        chk("R2 first sample", energy, mscale(AW'(36'sh300000), 8'd1));
        repeat (11) @(negedge clk);
        chk("R2 held between samples", energy, mscale(AW'(36'sh300000), 8'd1));

        // table walk: R3, R4
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {pa, pb, pc, dsel} = VEC[v][95:16];
            repeat (int'(VEC[v][15:0])) @(negedge clk);
            chk_all("R3/R4 vector");
        end

        // R6: read off the sampling edge
        do_reset();
        pa = 24'h200000; pb = 24'h200000; pc = 24'h200000; dsel = 8'd1;
        repeat (40) @(negedge clk);
        while (mcnt == 11) @(negedge clk);
        rd = 1'b1;
        chk("R6 pre-clear value", energy_rc, mscale(mrc, dsel));
        chk("R6 pre-clear nonzero", {23'd0, energy_rc != 0}, 24'd1);
        @(negedge clk); rd = 1'b0;
        chk("R6 cleared", energy_rc, 24'd0);
        chk("R6 main untouched", energy, mscale(macc, dsel));

        // R7: read on the sampling edge keeps the sample
        while (mcnt != 11) @(negedge clk);
        rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk("R7 sample kept", energy_rc, mscale(AW'(36'sh600000), 8'd1));
        repeat (12) @(negedge clk);
        chk("R7 continues", energy_rc, mscale(AW'(36'shC00000), 8'd1));

        // R8: negative half crossing with interrupts disabled
        do_reset();
        ien = 1'b0;
        pa = 24'h800000; pb = 24'h800000; pc = 24'h800000; dsel = 8'd1;
        while (!mzone(mscale(macc, dsel))) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8 disabled no flag", {23'd0, irq_flag}, 24'd0);
        chk("R8 negative zone", energy[23:22], 24'd2);

        // R8/R9/R5/R10: positive run to half scale and on through the wrap
        do_reset();
        ien = 1'b1;
        pa = 24'h7FFFFF; pb = 24'h7FFFFF; pc = 24'h7FFFFF; dsel = 8'd0;
        while (!mzone(mscale(macc, dsel))) @(negedge clk);
        chk("R8 not yet set", {23'd0, irq_flag}, 24'd0);
        @(negedge clk);
        chk("R8 flag set", {23'd0, irq_flag}, 24'd1);
        repeat (30) @(negedge clk);
        chk("R9 flag held", {23'd0, irq_flag}, 24'd1);
        iack = 1'b1; @(negedge clk); iack = 1'b0;
        chk("R9 acked", {23'd0, irq_flag}, 24'd0);
        while (mscale(macc, dsel) != 24'h800000 && !mscale(macc, dsel)[23]) @(negedge clk);
        e1 = energy;
        chk("R5 wrapped", e1, mscale(macc, dsel));
        chk("R5 negative full scale", {23'd0, e1[23]}, 24'd1);
        repeat (120) @(negedge clk);
        e2 = energy;
        chk("R5 still increasing", {23'd0, (e2 > e1)}, 24'd1);
        chk("R10 no flag at wrap", {23'd0, irq_flag}, 24'd0);
        chk_all("R5/R10 final");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule